// File: doc/BRIEF.md
# Register-Programmed SPI Shift Engine

This block is an SPI host that software runs through a small 32-bit register bus. Software first turns on register-driven operation and picks a clock divider. It then loads up to 32 bits of outgoing data and writes a shift command. The command carries a chip-select mask, a bit count and a release flag. The engine drives the serial clock, the outgoing data line and three active-low chip selects, and it samples the incoming data line. The received bits end up right-aligned in a readable register.

Each command moves one word of 1 to 32 bits. The release flag decides whether the chip select goes high when the word ends. With the flag clear, the chip select stays low, so several commands can be chained into one longer bus transaction. The bus runs in SPI mode 0: the clock idles low, the outgoing line changes when the clock falls, and the incoming line is captured when it rises.

Top module: `spiShiftEngine`

## Requirements
- R1: After reset the mode and divider registers read 0 and the pin register reads 0x0007_0000. The shift register reads 0. All chip-select outputs are high, and the clock and outgoing data outputs are low.
- R2: Word addresses: 0x00 is mode (bit 0 enables), 0x04 is the divider (bits 5:0), 0x08 is the pin register (bits 18:16), 0x10 is transmit data, 0x14 is shift command/status, and 0x18 is received data. Registers read back as written within their fields, and any other address reads 0.
- R3: With divider value d, the clock stays low for d+1 cycles after a command is accepted. It then alternates high and low, each level lasting d+1 cycles. It is low whenever the engine is idle.
- R4: A write to 0x14 with bit 31 set starts a shift of N = bits 5:0 bits when the engine is enabled and idle. Bit 31 of 0x14 reads 1 while the engine is busy and 0 otherwise. For 1 ≤ N ≤ 32, busy clears exactly 2·(d+1)·N cycles after the accepting clock edge, and exactly N rising clock edges occur.
- R5: Transmit bit N-1 goes out first and the lower bits follow in descending order. The outgoing line changes only while the clock is low, and it is low while the engine is idle.
- R6: The incoming line is captured at each rising clock edge and shifted into bit 0, with older bits moving left. After the shift, 0x18 holds the N received bits right-aligned, with bits above N-1 at zero.
- R7: Bits 30:28 of the command are a chip-select mask (bit 28+n drives chip select n). The selected outputs go low at the accepting edge, at least d+1 cycles before the first rising clock. With bit 26 set they return high when busy clears. With bit 26 clear they stay low.
- R8: A shift-command write while busy is ignored. The running shift keeps its bit count and timing.
- R9: With mode bit 0 clear, shift commands are ignored: busy stays 0, no clock edges occur and the chip selects do not move.
- R10: A command with N = 0 or N > 32 reads busy for one cycle only. It produces no clock edges and leaves the chip-select outputs unchanged.
- R11: Pin register bit 16+n sets the level of chip select n whenever the engine is not holding that select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Outgoing serial data |
| spiMiso | input | 1 | Incoming serial data |
| spiCsN | output | 3 | Active-low chip selects |

## Verification
A wrong phase counter shows on the very next clock transition. The measured half period or the busy duration then moves away from 2·(d+1)·N, so a divider fault appears within the first bit time. A bit-count or shifter fault shows when busy clears: the external slave's captured word, the rising-edge count or the right-aligned received value is wrong at the end of that command. A stale chip-select hold shows after a terminating command, at the first idle cycle, as a select that is still low.

// File: rtl/spiEnginePkg.sv
package spiEnginePkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 6;
  localparam int BUSY_BIT = 31;
  localparam int CS_LSB   = 28;
  localparam int TERM_BIT = 26;
  localparam int PIN_LSB  = 16;

  localparam logic [4:0] ADDR_MODE  = 5'h00;
  localparam logic [4:0] ADDR_DIV   = 5'h04;
  localparam logic [4:0] ADDR_PIN   = 5'h08;
  localparam logic [4:0] ADDR_TX    = 5'h10;
  localparam logic [4:0] ADDR_SHIFT = 5'h14;
  localparam logic [4:0] ADDR_RX    = 5'h18;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // accept a valid command
    logic sample;  // clock rises this edge
    logic shift;   // clock falls this edge
    logic finish;  // last falling edge of the word
  } shiftStrobe_t;
endpackage

// File: rtl/spiRegs.sv
module spiRegs
  import spiEnginePkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic              busy,
  input  logic [WORD_W-1:0] rxData,
  output logic              modeEn,
  output logic [DIV_W-1:0]  divVal,
  output logic [WORD_W-1:0] txData,
  output logic [NUM_CS-1:0] pinIdle,
  output logic              cmdWr
);
  logic [4:0] addrLo;
  assign addrLo = 5'(busAddr);

  assign cmdWr = busWrEn && (addrLo == ADDR_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn  <= 1'b0;
      divVal  <= '0;
      txData  <= '0;
      pinIdle <= '1;
    end else if (busWrEn) begin
      case (addrLo)
        ADDR_MODE: modeEn  <= busWrData[0];
        ADDR_DIV:  divVal  <= busWrData[DIV_W-1:0];
        ADDR_PIN:  pinIdle <= busWrData[PIN_LSB +: NUM_CS];
        ADDR_TX:   txData  <= busWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdData = '0;
    case (addrLo)
      ADDR_MODE:  busRdData[0] = modeEn;
      ADDR_DIV:   busRdData[DIV_W-1:0] = divVal;
      ADDR_PIN:   busRdData[PIN_LSB +: NUM_CS] = pinIdle;
      ADDR_TX:    busRdData = txData;
      ADDR_SHIFT: busRdData[BUSY_BIT] = busy;
      ADDR_RX:    busRdData = rxData;
      default: ;
    endcase
  end
endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiEnginePkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic             cmdGo,
  input  logic             modeEn,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [DIV_W-1:0] divVal,
  output shiftStrobe_t     strb,
  output logic             busy,
  output logic             sclk
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_NOP} ctrlState_t;

  ctrlState_t       state;
  logic [DIV_W-1:0] halfCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic             sclkQ;
  logic             accept;
  logic             countOk;
  logic             halfDone;

  assign countOk  = (cmdCount != '0) && (cmdCount <= CNT_W'(WORD_W));
  assign accept   = cmdWr && cmdGo && modeEn && (state == ST_IDLE);
  assign halfDone = (halfCnt == '0);

  assign strb.load   = accept && countOk;
  assign strb.sample = (state == ST_LOW) && halfDone;
  assign strb.shift  = (state == ST_HIGH) && halfDone;
  assign strb.finish = strb.shift && (bitsLeft == CNT_W'(1));

  assign busy = (state != ST_IDLE);
  assign sclk = sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      bitsLeft <= '0;
      sclkQ    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (countOk) begin
              state    <= ST_LOW;
              halfCnt  <= divVal;
              bitsLeft <= cmdCount;
            end else begin
              state <= ST_NOP;
            end
          end
        end
        ST_LOW: begin
          if (halfDone) begin
            sclkQ   <= 1'b1;
            halfCnt <= divVal;
            state   <= ST_HIGH;
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            sclkQ <= 1'b0;
            if (bitsLeft == CNT_W'(1)) begin
              state <= ST_IDLE;
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
              halfCnt  <= divVal;
              state    <= ST_LOW;
            end
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: clock idles low
  p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R9: disabled engine never goes busy
  p_disabled_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !modeEn && !busy) |=> !busy);

  // R8: a command while busy does not end or restart the shift
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWr && (state != ST_NOP) && !strb.finish) |=> busy);

  // R10: out-of-range count is busy for one cycle, no clock
  p_null_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !countOk) |=> (busy && !sclk));
  p_null_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !countOk) |-> ##2 !busy);
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiEnginePkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strb,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [NUM_CS-1:0] cmdCsMask,
  input  logic              cmdTerm,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              mosiBit,
  output logic [WORD_W-1:0] rxData,
  output logic [NUM_CS-1:0] csHeld
);
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic              termQ;
  logic [CNT_W-1:0]  alignAmt;

  // Left-align the transmit word so its first bit sits at the top
  assign alignAmt = CNT_W'(WORD_W) - cmdCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      termQ   <= 1'b0;
      csHeld  <= '0;
    end else begin
      if (strb.load) begin
        txShift <= txData << alignAmt;
        rxShift <= '0;
        termQ   <= cmdTerm;
        csHeld  <= cmdCsMask;
      end else begin
        if (strb.sample) rxShift <= {rxShift[WORD_W-2:0], miso};
        if (strb.shift)  txShift <= {txShift[WORD_W-2:0], 1'b0};
        if (strb.finish && termQ) csHeld <= '0;
      end
    end
  end

  assign mosiBit = txShift[WORD_W-1];
  assign rxData  = rxShift;

  // R7: terminating word releases every held select
  p_cs_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && termQ) |=> (csHeld == '0));

  // R6: a new word starts with an empty receive register
  p_rx_fresh_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (rxData == '0));
endmodule

// File: rtl/spiShiftEngine.sv
module spiShiftEngine
  import spiEnginePkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_CS-1:0] spiCsN
);
  shiftStrobe_t      strb;
  logic              modeEn;
  logic [DIV_W-1:0]  divVal;
  logic [WORD_W-1:0] txData;
  logic [WORD_W-1:0] rxData;
  logic [NUM_CS-1:0] pinIdle;
  logic [NUM_CS-1:0] csHeld;
  logic              cmdWr;
  logic              busy;
  logic              mosiBit;

  spiRegs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .busy(busy),
    .rxData(rxData), .modeEn(modeEn), .divVal(divVal), .txData(txData),
    .pinIdle(pinIdle), .cmdWr(cmdWr)
  );

  spiCtrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdGo(busWrData[BUSY_BIT]),
    .modeEn(modeEn), .cmdCount(busWrData[CNT_W-1:0]), .divVal(divVal),
    .strb(strb), .busy(busy), .sclk(spiSclk)
  );

  spiDatapath #(.NUM_CS(NUM_CS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdCount(busWrData[CNT_W-1:0]),
    .cmdCsMask(busWrData[CS_LSB +: NUM_CS]),
    .cmdTerm(busWrData[TERM_BIT]), .txData(txData), .miso(spiMiso),
    .mosiBit(mosiBit), .rxData(rxData), .csHeld(csHeld)
  );

  assign spiMosi = busy ? mosiBit : 1'b0;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign spiCsN[n] = csHeld[n] ? 1'b0 : pinIdle[n];
  end

  // R5: outgoing data is steady while the clock is high
  p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && spiSclk) |-> $stable(spiMosi));

  // R5: outgoing data is low while idle
  p_mosi_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiMosi);
endmodule

// File: tb/spiShiftEngine_bench.sv
module spiShiftEngine_bench;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        spiSclk, spiMosi, spiMiso;
  logic [2:0]  spiCsN;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiShiftEngine u_spiShiftEngine (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  // Slave model: counts clock edges, captures outgoing bits, serves a pattern
  logic [31:0] slavePat = '0;
  logic [31:0] capt = '0;
  int fallBase = 0, fallCnt = 0, riseCnt = 0;
  logic prevSclk = 1'b0;
  int pIdx;
  assign pIdx = fallCnt - fallBase;
  assign spiMiso = (pIdx >= 0 && pIdx < 32) ? slavePat[31 - pIdx] : 1'b0;

  always @(negedge clk) begin
    if (spiSclk && !prevSclk) begin
      riseCnt = riseCnt + 1;
      capt = {capt[30:0], spiMosi};
    end
    if (!spiSclk && prevSclk) fallCnt = fallCnt + 1;
    prevSclk = spiSclk;
  end

  typedef struct packed {
    logic [5:0]  dv;
    logic [5:0]  cnt;
    logic [2:0]  cs;
    logic        term;
    logic [31:0] tx;
    logic [31:0] pat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  6'd8,  3'b001, 1'b1, 32'h0000_00A5, 32'h3C00_0000},
    '{6'd1,  6'd16, 3'b010, 1'b1, 32'h0000_1234, 32'hBEEF_0000},
    '{6'd3,  6'd24, 3'b100, 1'b1, 32'h00C0_FFEE, 32'h8142_2400},
    '{6'd0,  6'd32, 3'b001, 1'b1, 32'hDEAD_BEEF, 32'h5A5A_F00F},
    '{6'd63, 6'd8,  3'b010, 1'b1, 32'h0000_0001, 32'h8000_0000},
    '{6'd2,  6'd5,  3'b001, 1'b1, 32'h0000_0013, 32'hF800_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [31:0] cmdWord(input logic [5:0] n, input logic [2:0] cs, input logic term);
    return 32'h8000_0000 | (32'(cs) << 28) | (32'(term) << 26) | 32'(n);
  endfunction

  // Issue a command and follow it to completion, sampling just after each falling clk edge
  task automatic runCmd(input logic [5:0] n, input logic [2:0] cs, input logic term,
                        output int cyc, output int firstRise, output int rises,
                        output logic [2:0] csAtStart);
    int rb;
    rb = riseCnt;
    firstRise = -1;
    busWrite(5'h14, cmdWord(n, cs, term));
    busAddr = 5'h14;
    cyc = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); #1;
      if (k == 0) csAtStart = spiCsN;
      if (spiSclk && firstRise < 0) firstRise = cyc;
      if (!busRdData[31]) break;
      cyc++;
    end
    rises = riseCnt - rb;
  endtask

  logic [31:0] rd;
  int cyc, fr, rs;
  logic [2:0] cs0;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk("R1 csN", 32'(spiCsN), 32'h7);
    chk("R1 sclk", 32'(spiSclk), 32'h0);
    chk("R1 mosi", 32'(spiMosi), 32'h0);
    rstN = 1'b1;
    busRead(5'h00, rd); chk("R1 mode", rd, 32'h0);
    busRead(5'h04, rd); chk("R1 div", rd, 32'h0);
    busRead(5'h08, rd); chk("R1 pin", rd, 32'h0007_0000);
    busRead(5'h14, rd); chk("R1 shift", rd, 32'h0);

    // R9: commands ignored while disabled
    busWrite(5'h10, 32'hFF);
    runCmd(6'd8, 3'b001, 1'b1, cyc, fr, rs, cs0);
    chk("R9 busy cycles", 32'(cyc), 32'h0);
    repeat (10) @(negedge clk);
    chk("R9 no clock", 32'(riseCnt), 32'h0);
    chk("R9 cs idle", 32'(spiCsN), 32'h7);

    busWrite(5'h00, 32'h1);
    busRead(5'h00, rd); chk("R2 mode readback", rd, 32'h1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      busWrite(5'h04, 32'(VECS[v].dv));
      busRead(5'h04, rd); chk("R2 div readback", rd, 32'(VECS[v].dv));
      busWrite(5'h10, VECS[v].tx);
      busRead(5'h10, rd); chk("R2 tx readback", rd, VECS[v].tx);
      slavePat = VECS[v].pat;
      fallBase = fallCnt;
      runCmd(VECS[v].cnt, VECS[v].cs, VECS[v].term, cyc, fr, rs, cs0);
      chk("R4 busy duration", 32'(cyc), 32'(2 * (int'(VECS[v].dv) + 1) * int'(VECS[v].cnt)));
      chk("R4 rising edges", 32'(rs), 32'(VECS[v].cnt));
      chk("R3 first rise", 32'(fr), 32'(int'(VECS[v].dv) + 1));
      chk("R7 cs asserted", 32'(cs0), 32'(~VECS[v].cs & 3'b111));
      chk("R7 cs released", 32'(spiCsN), 32'h7);
      chk("R5 mosi order",
          (VECS[v].cnt == 6'd32) ? capt : (capt & ((32'h1 << VECS[v].cnt) - 1)),
          (VECS[v].cnt == 6'd32) ? VECS[v].tx : (VECS[v].tx & ((32'h1 << VECS[v].cnt) - 1)));
      busRead(5'h18, rd);
      chk("R6 rx aligned", rd, VECS[v].pat >> (32 - int'(VECS[v].cnt)));
    end

    // R7 chained words keep the select low between commands
    busWrite(5'h04, 32'h0);
    slavePat = 32'hA1B2_C3D4;
    fallBase = fallCnt;
    busWrite(5'h10, 32'h11);
    runCmd(6'd8, 3'b001, 1'b0, cyc, fr, rs, cs0);
    chk("R7 held after term0", 32'(spiCsN), 32'h6);
    busRead(5'h18, rd); chk("R6 chain word1", rd, 32'hA1);
    // R10 zero count while a select is held: unchanged, one busy cycle
    runCmd(6'd0, 3'b001, 1'b1, cyc, fr, rs, cs0);
    chk("R10 zero busy", 32'(cyc), 32'h1);
    chk("R10 zero no clock", 32'(rs), 32'h0);
    chk("R10 zero cs kept", 32'(spiCsN), 32'h6);
    busWrite(5'h10, 32'h22);
    runCmd(6'd8, 3'b001, 1'b1, cyc, fr, rs, cs0);
    chk("R7 released after term1", 32'(spiCsN), 32'h7);
    busRead(5'h18, rd); chk("R6 chain word2", rd, 32'hB2);
    chk("R5 chain tx", capt & 32'hFFFF, 32'h1122);

    // R10 count above 32
    runCmd(6'd40, 3'b010, 1'b0, cyc, fr, rs, cs0);
    chk("R10 over busy", 32'(cyc), 32'h1);
    chk("R10 over no clock", 32'(rs), 32'h0);
    chk("R10 over cs", 32'(spiCsN), 32'h7);

    // R8 command while busy is ignored
    busWrite(5'h04, 32'h1);
    slavePat = 32'hC300_0000;
    fallBase = fallCnt;
    busWrite(5'h10, 32'h5A);
    begin
      int rb;
      rb = riseCnt;
      busWrite(5'h14, cmdWord(6'd8, 3'b001, 1'b1));
      repeat (5) @(negedge clk);
      busWrite(5'h14, cmdWord(6'd32, 3'b100, 1'b0));
      busAddr = 5'h14;
      for (int k = 0; k < 5000; k++) begin
        @(negedge clk); #1;
        if (!busRdData[31]) break;
      end
      chk("R8 edges unchanged", 32'(riseCnt - rb), 32'd8);
      chk("R8 cs unaffected", 32'(spiCsN), 32'h7);
      busRead(5'h18, rd); chk("R8 rx unchanged", rd, 32'hC3);
    end

    // R11 pin register drives idle selects
    busWrite(5'h08, 32'h0005_0000);
    @(negedge clk); #1;
    chk("R11 cs1 low", 32'(spiCsN), 32'h5);
    busWrite(5'h08, 32'h0007_0000);
    @(negedge clk); #1;
    chk("R11 restore", 32'(spiCsN), 32'h7);

    // R2 unused address reads zero
    busRead(5'h0C, rd); chk("R2 unused", rd, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule